// File: doc/BRIEF.md
# Prioritized Interrupt Controller with In-Service Tracking

This block collects up to sixteen interrupt events, latches each into a per-channel pending bit and raises one request line toward the processor. When the processor runs an acknowledge cycle, the controller answers with an 8-bit vector. The vector is built from a programmable base and the number of the winning channel. Channel 15 has the highest priority and channel 0 the lowest.

One mode bit selects between two end-of-interrupt schemes. In automatic mode, delivering a vector simply consumes the pending bit. In software mode, delivering a vector also marks the channel as in service. That channel, and every channel below it, then stays quiet until software clears the in-service bit. Software reaches the enable, mask, pending, in-service and vector registers through a flat write/read port. The pending and in-service registers can only be cleared from software, never set. A chain input and a chain output let several controllers share one acknowledge: the first controller in the chain that has a qualifying request answers, and the others pass the chain on.

Top module: `prio_intc`

## Requirements
- R1: After reset the enable, mask, pending, in-service and vector registers read zero, `irq_req` is low and `vec_valid` is low.
- R2: A one-cycle pulse on `src[i]` sets pending bit i when enable bit i (register address 0) is one. When enable bit i is zero, the pulse is ignored.
- R3: Mask register (address 1) bit i = 0 lets channel i latch pending but keeps it from raising `irq_req` or winning an acknowledge.
- R4: Of the requesting channels, the highest-numbered one wins. The vector is {vector register bits 7:4, 4-bit channel number}.
- R5: With vector register bit 3 = 0 (automatic mode), delivering a vector clears that channel's pending bit and all in-service bits stay zero.
- R6: With vector register bit 3 = 1 (software mode), delivering a vector clears the channel's pending bit and sets its in-service bit (register address 3).
- R7: While in-service bit k is set, channels k and below raise no request and supply no vector. Their pending bits still latch.
- R8: While in-service bit k is set, a channel above k still requests and is acknowledged.
- R9: Writing the pending register (address 2) or the in-service register (address 3) clears each bit written as zero and leaves each bit written as one unchanged. A one never sets a bit.
- R10: During `iack`, the block drives `vec_valid` only if `chain_in` is high and it has a qualifying request, and it then holds `chain_out` low. Otherwise `chain_out` follows `chain_in` and no vector is driven.
- R11: Writing the vector register with bit 3 = 0 clears every in-service bit at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src | input | 16 | Per-channel event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 enable, 1 mask, 2 pending, 3 in-service, 4 vector) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 16 | Read data |
| iack | input | 1 | Acknowledge cycle strobe |
| chain_in | input | 1 | Chain grant from the previous controller |
| chain_out | output | 1 | Chain grant to the next controller |
| irq_req | output | 1 | Interrupt request |
| vec_valid | output | 1 | Vector is being driven |
| vec_out | output | 8 | Vector |

## Verification
The bench fires two channels in the same cycle to confirm that the higher one wins. A reversed priority encoder would return the lower vector. Software mode is exercised with a lower channel and a same channel pending behind an in-service bit. A design that compared the in-service bit with the wrong inequality would either let these through or block a higher channel. The clear-only writes are tested with all-ones patterns, which a plain write would turn into set bits. The bench also drops out of software mode with an in-service bit held, which a design that kept in-service state across the mode change would leave stuck. Acknowledges with the chain input low, and with nothing qualifying, confirm that the chain is passed on rather than swallowed.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NCH = 16,
  parameter int VW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] src,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [NCH-1:0] wr_data,
  input  logic [2:0]     rd_addr,
  output logic [NCH-1:0] rd_data,
  input  logic           iack,
  input  logic           chain_in,
  output logic           chain_out,
  output logic           irq_req,
  output logic           vec_valid,
  output logic [VW-1:0]  vec_out
);
  localparam int IDW = $clog2(NCH);
  localparam logic [2:0] A_EN = 3'd0, A_MSK = 3'd1, A_PEND = 3'd2, A_ISR = 3'd3, A_VEC = 3'd4;

  logic [NCH-1:0] en_q, msk_q, pend_q, isr_q;
  logic [VW-1:0]  vr_q;
  logic           sw_q, sw_d;
  logic [IDW-1:0] top_idx, isr_idx;
  logic           top_any, isr_any, qual, grant;
  logic [NCH-1:0] req_v, gnt_oh, pend_clr, isr_clr;

  assign sw_q  = vr_q[IDW-1];
  assign req_v = pend_q & msk_q;

  always_comb begin
    top_idx = '0; top_any = 1'b0;
    isr_idx = '0; isr_any = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (req_v[i]) begin top_idx = IDW'(i); top_any = 1'b1; end
      if (isr_q[i]) begin isr_idx = IDW'(i); isr_any = 1'b1; end
    end
  end

  assign qual      = top_any && (!isr_any || top_idx > isr_idx);
  assign irq_req   = qual;
  assign grant     = iack && chain_in && qual;
  assign vec_valid = grant;
  assign vec_out   = grant ? {vr_q[VW-1:IDW], top_idx} : '0;
  assign chain_out = chain_in && !grant;
  assign gnt_oh    = grant ? (NCH'(1) << top_idx) : '0;

  assign pend_clr = (wr_en && wr_addr == A_PEND) ? ~wr_data : '0;
  assign isr_clr  = (wr_en && wr_addr == A_ISR)  ? ~wr_data : '0;
  assign sw_d     = (wr_en && wr_addr == A_VEC) ? wr_data[IDW-1] : sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      msk_q  <= '0;
      pend_q <= '0;
      isr_q  <= '0;
      vr_q   <= '0;
    end else begin
      if (wr_en && wr_addr == A_EN)  en_q  <= wr_data;
      if (wr_en && wr_addr == A_MSK) msk_q <= wr_data;
      if (wr_en && wr_addr == A_VEC) vr_q  <= wr_data[VW-1:0];
      pend_q <= (pend_q & ~pend_clr & ~gnt_oh) | (src & en_q);
      isr_q  <= sw_d ? ((isr_q & ~isr_clr) | (sw_q ? gnt_oh : '0)) : '0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_EN:    rd_data = en_q;
      A_MSK:   rd_data = msk_q;
      A_PEND:  rd_data = pend_q;
      A_ISR:   rd_data = isr_q;
      A_VEC:   rd_data = NCH'(vr_q);
      default: rd_data = '0;
    endcase
  end
endmodule

module prio_intc_chk #(
  parameter int NCH = 16,
  parameter int VW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] src,
  input logic           wr_en,
  input logic           iack,
  input logic           chain_in,
  input logic           chain_out,
  input logic           irq_req,
  input logic           vec_valid,
  input logic [VW-1:0]  vec_out,
  input logic [NCH-1:0] pend_q,
  input logic [NCH-1:0] msk_q,
  input logic [NCH-1:0] isr_q,
  input logic           sw_q
);
  localparam int IDW = $clog2(NCH);

  assert_vec_needs_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (iack && chain_in));
  assert_vec_blocks_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !chain_out);
  assert_req_needs_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pend_q & msk_q) != '0));
  assert_auto_isr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_q |-> (isr_q == '0));
  assert_grant_clears_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !src[vec_out[IDW-1:0]]) |=> !pend_q[$past(vec_out[IDW-1:0])]);
  assert_grant_sets_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && sw_q && !wr_en) |=> isr_q[$past(vec_out[IDW-1:0])]);
endmodule

bind prio_intc prio_intc_chk #(.NCH(NCH), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .iack(iack),
  .chain_in(chain_in), .chain_out(chain_out), .irq_req(irq_req),
  .vec_valid(vec_valid), .vec_out(vec_out), .pend_q(pend_q),
  .msk_q(msk_q), .isr_q(isr_q), .sw_q(sw_q)
);

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] src = '0, wr_data = '0, rd_data;
  logic        wr_en = 1'b0, iack = 1'b0, chain_in = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic        chain_out, irq_req, vec_valid;
  logic [7:0]  vec_out;
  int n_chk = 0, n_bad = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #2 clk = ~clk;

  prio_intc dut_i (.*);

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] s);
    @(negedge clk); src = s;
    @(negedge clk); src = '0;
  endtask

  task automatic rd_chk(string tag, input logic [2:0] a, input int exp);
    rd_addr = a; #1;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic ack(string tag, input logic ci, input logic ev, input logic eco, input logic [7:0] evec);
    exp_q.push_back({ev, eco, evec});
    tag_q.push_back(tag);
    @(negedge clk); iack = 1'b1; chain_in = ci;
    @(negedge clk); iack = 1'b0; chain_in = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (iack) begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " valid"}, int'(vec_valid), int'(e[9]));
        check({t, " chain"}, int'(chain_out), int'(e[8]));
        check({t, " vec"}, int'(vec_out), int'(e[7:0]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 enable", 3'd0, 0);
    rd_chk("R1 mask", 3'd1, 0);
    rd_chk("R1 pending", 3'd2, 0);
    rd_chk("R1 inservice", 3'd3, 0);
    rd_chk("R1 vector", 3'd4, 0);
    check("R1 irq", int'(irq_req), 0);
    check("R1 vec_valid", int'(vec_valid), 0);

    wr(3'd0, 16'hFFFB);
    wr(3'd1, 16'hFFFF);
    wr(3'd4, 16'h00A0);
    pulse(16'h0004);
    rd_chk("R2 disabled ignored", 3'd2, 0);
    pulse(16'h0020);
    rd_chk("R2 enabled latches", 3'd2, 16'h0020);
    check("R2 irq", int'(irq_req), 1);

    wr(3'd1, 16'hFFDF);
    #1 check("R3 masked no irq", int'(irq_req), 0);
    rd_chk("R3 pending kept", 3'd2, 16'h0020);
    ack("R3 masked no vector", 1'b1, 1'b0, 1'b1, 8'h00);
    wr(3'd1, 16'hFFFF);

    pulse(16'h0200);
    rd_chk("R4 two pending", 3'd2, 16'h0220);
    ack("R4 highest wins", 1'b1, 1'b1, 1'b0, 8'hA9);
    rd_chk("R5 pending cleared", 3'd2, 16'h0020);
    rd_chk("R5 isr zero", 3'd3, 0);
    ack("R5 next channel", 1'b1, 1'b1, 1'b0, 8'hA5);
    rd_chk("R5 all consumed", 3'd2, 0);
    check("R5 irq low", int'(irq_req), 0);

    pulse(16'h0008);
    ack("R10 chain low", 1'b0, 1'b0, 1'b0, 8'h00);
    rd_chk("R10 pending kept", 3'd2, 16'h0008);
    wr(3'd2, 16'hFFF7);
    rd_chk("R9 pending write clear", 3'd2, 0);
    ack("R10 pass through", 1'b1, 1'b0, 1'b1, 8'h00);

    pulse(16'h0012);
    wr(3'd2, 16'hFFFF);
    rd_chk("R9 ones keep pending", 3'd2, 16'h0012);
    wr(3'd2, 16'hFFEF);
    rd_chk("R9 single clear", 3'd2, 16'h0002);
    wr(3'd2, 16'h0000);
    rd_chk("R9 clear all", 3'd2, 0);

    wr(3'd4, 16'h00A8);
    pulse(16'h0040);
    ack("R6 sw vector", 1'b1, 1'b1, 1'b0, 8'hA6);
    rd_chk("R6 isr set", 3'd3, 16'h0040);
    rd_chk("R6 pending cleared", 3'd2, 0);
    pulse(16'h0050);
    rd_chk("R7 lower latches", 3'd2, 16'h0050);
    check("R7 no irq", int'(irq_req), 0);
    ack("R7 blocked", 1'b1, 1'b0, 1'b1, 8'h00);
    pulse(16'h1000);
    check("R8 higher irq", int'(irq_req), 1);
    ack("R8 higher acked", 1'b1, 1'b1, 1'b0, 8'hAC);
    rd_chk("R8 isr both", 3'd3, 16'h1040);
    check("R7 irq after nest", int'(irq_req), 0);
    wr(3'd3, 16'hEFFF);
    rd_chk("R9 isr clear", 3'd3, 16'h0040);
    check("R7 same channel blocked", int'(irq_req), 0);
    wr(3'd3, 16'hFFBF);
    rd_chk("R9 isr cleared", 3'd3, 0);
    wr(3'd3, 16'hFFFF);
    rd_chk("R9 ones no set", 3'd3, 0);
    check("R7 released", int'(irq_req), 1);
    ack("R7 second event served", 1'b1, 1'b1, 1'b0, 8'hA6);
    rd_chk("R6 isr again", 3'd3, 16'h0040);
    rd_chk("R6 pending left", 3'd2, 16'h0010);
    wr(3'd4, 16'h00A0);
    rd_chk("R11 isr dropped", 3'd3, 0);
    check("R11 irq", int'(irq_req), 1);
    ack("R11 auto vector", 1'b1, 1'b1, 1'b0, 8'hA4);
    rd_chk("R11 isr stays zero", 3'd3, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule